// File: doc/BRIEF.md
# Serial Character Receiver with Start-Glitch Rejection

This block takes one asynchronous serial line and turns each incoming character into eight parallel bits. A falling edge on the idle-high line starts a bit-slot timer. The start bit is checked again at the middle of its slot, so a short low pulse is rejected as a glitch rather than read as a character. Each of the eight data bits, least significant first, is sampled at the centre of its slot. A dedicated single-cycle strobe then loads that bit into its own holding register.

Once the stop bit has been sampled, a ready flag is raised and stays up until the consumer pulses an acknowledge input. Two more flags report a stop bit read as 0 and a character that completed while the previous one was still unacknowledged. Bit timing comes from a fixed internal divider that produces a tick at sixteen times the baud rate. The raw line and the eight strobes are available on ports, so external per-bit storage can follow the same sequence.

Top module: `serial_char_rx`

## Requirements
- R1: While reset is asserted and right after it, `ready_o`, `frame_err_o`, `overrun_o`, `strobe_o` and `data_o` are all 0.
- R2: A frame is a 0 start bit, eight data bits sent least significant bit first, then a stop bit, each lasting 16 ticks. After the frame, `data_o[i]` holds data bit i, sampled near the centre of its slot.
- R3: The receiver samples the start bit 8 ticks after the detected edge. If the line reads 1 at that point, the sequence aborts: no strobe fires, and `ready_o` and `data_o` keep their values. The next valid frame is received normally.
- R4: `strobe_o[i]` pulses for exactly one clock cycle, once per frame. At most one strobe bit is high in any cycle, and the pulses come in the order bit 0 to bit 7.
- R5: `data_o` changes only in the cycle after a strobe, and only in the strobed bit.
- R6: `ready_o` rises after the stop-bit sample and stays at 1 while `ack_i` is low.
- R7: A cycle with `ack_i` high clears `ready_o`, `frame_err_o` and `overrun_o`. If a frame completes in that same cycle, the completion takes precedence.
- R8: A stop bit read as 0 sets `frame_err_o` and still sets `ready_o`. The receiver then returns to idle.
- R9: A frame that completes while `ready_o` is 1 sets `overrun_o`, and `data_o` is replaced by the new character.
- R10: Frames sent back to back, with the next start bit right after the stop bit, are each captured correctly.
- R11: `rxd_o` always equals `rxd_i`.
- R12: Reception starts only on a 1-to-0 transition of the synchronized line. A line that stays low after a frame ends starts no new reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Master reset, asynchronous, active low |
| rxd_i | input | 1 | Serial input line, idle high |
| ack_i | input | 1 | Data-read acknowledge, clears the flags |
| rxd_o | output | 1 | Pass-through of the serial input |
| strobe_o | output | 8 | Per-bit capture strobes, one-cycle pulses |
| data_o | output | 8 | Received character |
| ready_o | output | 1 | Character available, held until acknowledged |
| frame_err_o | output | 1 | Stop bit of the last character read as 0 |
| overrun_o | output | 1 | A character completed while ready was still set |

## Verification
The bench first sends directed characters: all zeros, all ones and alternating patterns. These separate wrong bit order and stuck bits from correct centre sampling. Low pulses of four and six ticks check that mid-slot rejection aborts cleanly and that the receiver recovers. A stop bit of 0 followed by a long low line separates a correct framing error from a spurious restart. Two unacknowledged frames, and two frames sent back to back, exercise overrun and the return to idle at mid-stop. Random characters with random stop-bit errors and idle gaps then run against a bench model of the three flags.

// File: rtl/serial_char_rx_pkg.sv
package serial_char_rx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_phase_e;

  localparam int unsigned OVERSAMPLE = 16;
  localparam int unsigned WORD_BITS  = 8;
endpackage

// File: rtl/rx_tick_gen.sv
module rx_tick_gen #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] TOP = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick_o = (cnt_q == TOP);
    cnt_d  = tick_o ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rx_line_front.sv
module rx_line_front #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rxd_i,
  output logic line_o,
  output logic fall_o
);
  // stages 0..STAGES-1 synchronize, stage STAGES holds the previous value
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '1;
    else         pipe_q <= {pipe_q[STAGES-1:0], rxd_i};
  end

  assign line_o = pipe_q[STAGES-1];
  assign fall_o = pipe_q[STAGES] & ~pipe_q[STAGES-1];
endmodule

// File: rtl/rx_sequencer.sv
module rx_sequencer
  import serial_char_rx_pkg::*;
#(
  parameter int unsigned OVS   = OVERSAMPLE,
  parameter int unsigned NBITS = WORD_BITS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             line_i,
  input  logic             fall_i,
  output logic [NBITS-1:0] strobe_o,
  output logic             done_o,
  output logic             stop_ok_o
);
  localparam int unsigned CW = $clog2(OVS);
  localparam int unsigned IW = (NBITS > 1) ? $clog2(NBITS) : 1;
  localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);
  localparam logic [IW-1:0] TOPB = IW'(NBITS - 1);

  rx_phase_e     ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [IW-1:0] idx_q, idx_d;

  always_comb begin
    ph_d      = ph_q;
    cnt_d     = cnt_q;
    idx_d     = idx_q;
    strobe_o  = '0;
    done_o    = 1'b0;
    stop_ok_o = line_i;
    unique case (ph_q)
      RX_IDLE: begin
        if (fall_i) begin
          ph_d  = RX_START;
          cnt_d = '0;
        end
      end
      RX_START: begin
        if (tick_i) begin
          if (cnt_q == MID) begin
            cnt_d = '0;
            idx_d = '0;
            ph_d  = line_i ? RX_IDLE : RX_DATA;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      RX_DATA: begin
        if (tick_i) begin
          if (cnt_q == LAST) begin
            strobe_o[idx_q] = 1'b1;
            cnt_d = '0;
            if (idx_q == TOPB) ph_d = RX_STOP;
            else               idx_d = idx_q + 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      RX_STOP: begin
        if (tick_i) begin
          if (cnt_q == LAST) begin
            done_o = 1'b1;
            ph_d   = RX_IDLE;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: ph_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= RX_IDLE;
      cnt_q <= '0;
      idx_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      idx_q <= idx_d;
    end
  end
endmodule

// File: rtl/rx_bit_hold.sv
module rx_bit_hold #(
  parameter int unsigned NBITS = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             line_i,
  input  logic [NBITS-1:0] strobe_i,
  output logic [NBITS-1:0] data_o
);
  for (genvar g = 0; g < NBITS; g++) begin : g_cell
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          data_o[g] <= 1'b0;
      else if (strobe_i[g]) data_o[g] <= line_i;
    end
  end
endmodule

// File: rtl/serial_char_rx.sv
module serial_char_rx
  import serial_char_rx_pkg::*;
#(
  parameter int unsigned CLK_DIV = 4,
  parameter int unsigned NBITS   = WORD_BITS,
  parameter int unsigned OVS     = OVERSAMPLE
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rxd_i,
  input  logic             ack_i,
  output logic             rxd_o,
  output logic [NBITS-1:0] strobe_o,
  output logic [NBITS-1:0] data_o,
  output logic             ready_o,
  output logic             frame_err_o,
  output logic             overrun_o
);
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  logic tick, line, fall, frame_done, stop_ok;

  rx_tick_gen #(.DIV(CLK_DIV)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_n), .tick_o(tick)
  );

  rx_line_front #(.STAGES(2)) u_front (
    .clk_i(clk_i), .rst_ni(rst_n), .rxd_i(rxd_i),
    .line_o(line), .fall_o(fall)
  );

  rx_sequencer #(.OVS(OVS), .NBITS(NBITS)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_n), .tick_i(tick), .line_i(line),
    .fall_i(fall), .strobe_o(strobe_o), .done_o(frame_done),
    .stop_ok_o(stop_ok)
  );

  rx_bit_hold #(.NBITS(NBITS)) u_hold (
    .clk_i(clk_i), .rst_ni(rst_n), .line_i(line),
    .strobe_i(strobe_o), .data_o(data_o)
  );

  logic ready_d, ferr_d, over_d;

  always_comb begin
    ready_d = ready_o;
    ferr_d  = frame_err_o;
    over_d  = overrun_o;
    if (frame_done) begin
      ready_d = 1'b1;
      ferr_d  = ~stop_ok;
      over_d  = overrun_o | ready_o;
    end else if (ack_i) begin
      ready_d = 1'b0;
      ferr_d  = 1'b0;
      over_d  = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      ready_o     <= 1'b0;
      frame_err_o <= 1'b0;
      overrun_o   <= 1'b0;
    end else begin
      ready_o     <= ready_d;
      frame_err_o <= ferr_d;
      overrun_o   <= over_d;
    end
  end

  assign rxd_o = rxd_i;
endmodule

// File: rtl/serial_char_rx_chk.sv
module serial_char_rx_chk #(
  parameter int unsigned NBITS = 8
) (
  input logic             clk_i,
  input logic             rst_n,
  input logic             ack_i,
  input logic             frame_done,
  input logic [NBITS-1:0] strobe_o,
  input logic [NBITS-1:0] data_o,
  input logic             ready_o,
  input logic             frame_err_o,
  input logic             overrun_o
);
  assert_strobe_onehot_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    $onehot0(strobe_o));

  assert_strobe_single_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (strobe_o != '0) |=> (strobe_o == '0));

  assert_data_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (strobe_o == '0) |=> $stable(data_o));

  assert_ready_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (ready_o && !ack_i) |=> ready_o);

  assert_done_sets_ready_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    frame_done |=> ready_o);

  assert_ack_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    (ack_i && !frame_done) |=> (!ready_o && !frame_err_o && !overrun_o));

  assert_overrun_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
    (frame_done && ready_o) |=> overrun_o);
endmodule

bind serial_char_rx serial_char_rx_chk #(.NBITS(NBITS)) u_chk (
  .clk_i(clk_i), .rst_n(rst_n), .ack_i(ack_i), .frame_done(frame_done),
  .strobe_o(strobe_o), .data_o(data_o), .ready_o(ready_o),
  .frame_err_o(frame_err_o), .overrun_o(overrun_o)
);

// File: tb/serial_char_rx_tb.sv
module serial_char_rx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;
  localparam int BITC       = DIV * 16;
  localparam int WD_CYCLES  = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rxd = 1'b1;
  logic ack = 1'b0;
  logic       rxd_o, ready_o, frame_err_o, overrun_o;
  logic [7:0] strobe_o, data_o;

  always #(CLK_PERIOD / 2) clk = ~clk;

  serial_char_rx #(.CLK_DIV(DIV)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rxd_i(rxd), .ack_i(ack),
    .rxd_o(rxd_o), .strobe_o(strobe_o), .data_o(data_o),
    .ready_o(ready_o), .frame_err_o(frame_err_o), .overrun_o(overrun_o)
  );

  int n_chk = 0, n_bad = 0;
  int strb_cnt [8];
  int multi_bad = 0, order_bad = 0, pass_bad = 0;
  int last_idx = 7;
  logic [7:0] cap [4];
  int cap_n = 0;
  logic pend7 = 1'b0;
  bit finished = 1'b0;

  // model of the flags
  logic m_ready = 1'b0, m_ferr = 1'b0, m_over = 1'b0;

  initial for (int i = 0; i < 8; i++) strb_cnt[i] = 0;

  always @(negedge clk) begin
    if ($countones(strobe_o) > 1) multi_bad++;
    for (int i = 0; i < 8; i++) begin
      if (strobe_o[i]) begin
        strb_cnt[i]++;
        if (i != (last_idx + 1) % 8) order_bad++;
        last_idx = i;
      end
    end
    if (rxd_o !== rxd) pass_bad++;
    if (pend7) begin
      cap[cap_n % 4] = data_o;
      cap_n++;
    end
    pend7 = strobe_o[7];
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic next_over(input logic over, input logic rdy);
    return over | rdy;
  endfunction

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic stop, input int hold, input int gap);
    rxd = 1'b0; wait_cyc(BITC);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i]; wait_cyc(BITC);
    end
    rxd = stop; wait_cyc(BITC * (1 + hold));
    rxd = 1'b1; wait_cyc(BITC * gap);
  endtask

  task automatic frame_check(input logic [7:0] d, input logic stop, input int hold, input int gap);
    int base [8];
    for (int i = 0; i < 8; i++) base[i] = strb_cnt[i];
    send_frame(d, stop, hold, gap);
    m_over  = next_over(m_over, m_ready);
    m_ready = 1'b1;
    m_ferr  = ~stop;
    check(ready_o === 1'b1, "R6 ready after frame", ready_o, 1);
    check(data_o === d, "R2 data", data_o, d);
    check(frame_err_o === m_ferr, "R8 frame error", frame_err_o, m_ferr);
    check(overrun_o === m_over, "R9 overrun", overrun_o, m_over);
    for (int i = 0; i < 8; i++)
      check(strb_cnt[i] - base[i] == 1, (hold > 0) ? "R12 one strobe per bit" : "R4 one strobe per bit",
            strb_cnt[i] - base[i], 1);
  endtask

  task automatic do_ack();
    ack = 1'b1; wait_cyc(1);
    ack = 1'b0; wait_cyc(1);
    m_ready = 1'b0; m_ferr = 1'b0; m_over = 1'b0;
    check(ready_o === 1'b0, "R7 ack clears ready", ready_o, 0);
    check(frame_err_o === 1'b0, "R7 ack clears frame error", frame_err_o, 0);
    check(overrun_o === 1'b0, "R7 ack clears overrun", overrun_o, 0);
  endtask

  task automatic glitch(input int ticks);
    int base [8];
    logic [7:0] held;
    held = data_o;
    for (int i = 0; i < 8; i++) base[i] = strb_cnt[i];
    rxd = 1'b0; wait_cyc(ticks * DIV);
    rxd = 1'b1; wait_cyc(BITC * 12);
    check(ready_o === m_ready, "R3 glitch leaves ready", ready_o, m_ready);
    check(data_o === held, "R3 glitch leaves data", data_o, held);
    for (int i = 0; i < 8; i++)
      check(strb_cnt[i] == base[i], "R3 glitch fires no strobe", strb_cnt[i] - base[i], 0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=<%0d", WD_CYCLES, WD_CYCLES);
    summary();
  end

  initial begin
    int c0;
    logic [7:0] d;
    logic st;
    int gp;
    void'($urandom(32'd2024));
    wait_cyc(6);
    check({ready_o, frame_err_o, overrun_o} === 3'b000, "R1 flags in reset",
          {ready_o, frame_err_o, overrun_o}, 0);
    check(strobe_o === 8'h00, "R1 strobes in reset", strobe_o, 0);
    check(data_o === 8'h00, "R1 data in reset", data_o, 0);
    rst_n = 1'b1;
    wait_cyc(8);
    check({ready_o, frame_err_o, overrun_o, strobe_o, data_o} === '0, "R1 after release", ready_o, 0);

    frame_check(8'hA5, 1'b1, 0, 1);
    wait_cyc(BITC * 3);
    check(ready_o === 1'b1, "R6 ready held without ack", ready_o, 1);
    do_ack();
    frame_check(8'h00, 1'b1, 0, 1); do_ack();
    frame_check(8'hFF, 1'b1, 0, 1); do_ack();
    frame_check(8'h3C, 1'b0, 0, 1); do_ack();

    // R12: line stays low after a bad stop bit
    frame_check(8'hC3, 1'b0, 12, 1); do_ack();

    glitch(4);
    glitch(6);
    frame_check(8'h5A, 1'b1, 0, 1);
    check(data_o === 8'h5A, "R3 recovery after glitch", data_o, 8'h5A);
    do_ack();

    // R9 overrun
    frame_check(8'h11, 1'b1, 0, 1);
    frame_check(8'h22, 1'b1, 0, 1);
    do_ack();

    // R10 back to back
    c0 = cap_n;
    frame_check(8'h81, 1'b1, 0, 0);
    frame_check(8'h7E, 1'b1, 0, 1);
    check(cap[c0 % 4] === 8'h81, "R10 first of pair", cap[c0 % 4], 8'h81);
    check(cap[(c0 + 1) % 4] === 8'h7E, "R10 second of pair", cap[(c0 + 1) % 4], 8'h7E);
    do_ack();

    for (int k = 0; k < 40; k++) begin
      d  = 8'($urandom);
      st = (($urandom % 8) != 0);
      gp = int'($urandom % 3);
      frame_check(d, st, 0, gp);
      if (($urandom % 4) != 0) do_ack();
    end
    do_ack();

    check(multi_bad == 0, "R4 at most one strobe at a time", multi_bad, 0);
    check(order_bad == 0, "R4 strobe order", order_bad, 0);
    check(pass_bad == 0, "R11 pass-through", pass_bad, 0);
    summary();
  end
endmodule